// File: doc/BRIEF.md
# Sequenced Three-Input ADC Controller

This block is the register-mapped control logic for a 10-bit successive-approximation converter with three multiplexed inputs. Software picks an input through a select register, then writes a control register with the start and power bits both set. The block derives a converter clock from the bus clock through a programmable divisor and captures the selected input on the first converter tick. It then resolves the 10-bit code one bit per tick, starting at the MSB. At the end it latches the code and raises an interrupt. Reading the result register returns the code and drops the interrupt.

The analog front end is stood in for by a digital sample bus carrying one 10-bit value per input. The register window decodes a 12-bit byte offset. Writes and reads are single-cycle strobes. Read data is combinational from the address in the same cycle.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the select register (offset 0x04), the control register (offset 0x08) and the result register (offset 0x48) read 0, and the interrupt is low.
- R2: The select register keeps bits 9, 7, 5, 4 and 2 exactly as written. Its other bits read 0. Bits [5:4] hold the input code, so input n is written as n*0x10.
- R3: A select write with input code 3 makes conversions use input 0 and sets a sticky error flag (control bit 4). The flag survives conversions and is cleared only by a select write carrying code 0, 1 or 2.
- R4: A control write with bit 1 (start) and bit 2 (power) both set begins one conversion. Control bit 3 (busy) then reads 1 for exactly 11 converter ticks and drops on the 11th.
- R5: A start write whose power bit is clear begins no conversion. A start write during a busy conversion is ignored and does not move its completion.
- R6: Control bit 1 always reads 0. Bit 2 reads back the last power bit written.
- R7: The result register returns, in bits [9:0], the input that was selected at start and sampled on the first converter tick. Later changes to the select register or to the sample bus do not alter it. Bits [31:10] read 0.
- R8: Completion sets the interrupt. A read of offset 0x48 clears it. When completion and that read fall in the same cycle, the read returns the previous code and the interrupt stays set.
- R9: The clock register (offset 0x10) holds the divisor in bits [7:0] and the tick enable in bit 8. It resets to enable=1 with divisor floor(PCLK_KHZ/4500)+1, which is 23 by default. One tick occurs every divisor bus cycles, counted from the start write. While enable is 0 no tick occurs and a conversion stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 12 | Byte offset within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| ain | input | 30 | Sample bus, input n in bits [10n+9:10n] |
| irq | output | 1 | Conversion-complete interrupt, level |

## Verification
The completion of a conversion and a software read of the result register can land on the same clock edge. One sets the interrupt and replaces the code, while the other clears the interrupt. The bench starts a conversion with a known divisor and counts 11 divisor periods from the start write. It then places the result read exactly on the completion edge. It judges the outcome by checking three things: the read returns the old code, the interrupt is still high afterwards, and a second read returns the new code and clears the interrupt.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned BUS_AW = 12;
  localparam logic [BUS_AW-1:0] OFS_SEL  = 12'h004;
  localparam logic [BUS_AW-1:0] OFS_CTRL = 12'h008;
  localparam logic [BUS_AW-1:0] OFS_CLK  = 12'h010;
  localparam logic [BUS_AW-1:0] OFS_RES  = 12'h048;
  localparam logic [31:0] SEL_KEEP_MASK = 32'h0000_02B4;
  localparam int unsigned CLK_EN_BIT = 8;
  localparam int unsigned CH_W = 2;

  typedef enum logic [1:0] {SAR_IDLE, SAR_SAMPLE, SAR_APPROX} sar_state_e;

  // smallest divisor that keeps the converter clock at or below the limit
  function automatic int unsigned calc_divisor(input int unsigned pclk_khz,
                                               input int unsigned max_khz);
    return pclk_khz / max_khz + 1;
  endfunction

  function automatic logic chan_valid(input logic [CH_W-1:0] code,
                                      input int unsigned nch);
    return int'(code) < nch;
  endfunction
endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;

  // a divisor of zero behaves as one
  always_comb lim = (div_i == '0) ? '0 : div_i - 1'b1;

  assign tick_o = en_i && !clr_i && (cnt_q == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (en_i)   cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (!tick_o || lim == '0)); // R9
  AST_NO_TICK_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && $past(!en_i)) |-> $stable(cnt_q)); // R9
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core import adc_seq_pkg::*; #(
  parameter int unsigned NCH   = 3,
  parameter int unsigned RES_W = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [CH_W-1:0]      chan_i,
  input  logic                 tick_i,
  input  logic [NCH*RES_W-1:0] samples_i,
  output logic                 busy_o,
  output logic                 done_o,
  output logic [RES_W-1:0]     result_o
);
  localparam int unsigned BIT_W = $clog2(RES_W);

  sar_state_e        state_q;
  logic [CH_W-1:0]   chan_q;
  logic [RES_W-1:0]  hold_q;
  logic [RES_W-1:0]  acc_q;
  logic [RES_W-1:0]  acc_next;
  logic [RES_W-1:0]  sample_sel;
  logic [BIT_W-1:0]  bit_q;

  // one successive-approximation decision: keep the trial bit if it fits
  function automatic logic [RES_W-1:0] sar_step(input logic [RES_W-1:0] acc,
                                                input logic [RES_W-1:0] hold,
                                                input logic [BIT_W-1:0] b);
    logic [RES_W-1:0] trial;
    trial = acc | (RES_W'(1) << b);
    return (hold >= trial) ? trial : acc;
  endfunction

  always_comb sample_sel = samples_i[int'(chan_q)*RES_W +: RES_W];
  always_comb acc_next   = sar_step(acc_q, hold_q, bit_q);

  assign busy_o   = (state_q != SAR_IDLE);
  assign done_o   = (state_q == SAR_APPROX) && tick_i && (bit_q == '0);
  assign result_o = acc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SAR_IDLE;
      chan_q  <= '0;
      hold_q  <= '0;
      acc_q   <= '0;
      bit_q   <= '0;
    end else begin
      case (state_q)
        SAR_IDLE: if (start_i) begin
          state_q <= SAR_SAMPLE;
          chan_q  <= chan_i;
          acc_q   <= '0;
        end
        SAR_SAMPLE: if (tick_i) begin
          hold_q  <= sample_sel;
          bit_q   <= BIT_W'(RES_W - 1);
          state_q <= SAR_APPROX;
        end
        SAR_APPROX: if (tick_i) begin
          acc_q <= acc_next;
          if (bit_q == '0) state_q <= SAR_IDLE;
          else             bit_q   <= bit_q - 1'b1;
        end
        default: state_q <= SAR_IDLE;
      endcase
    end
  end

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o); // R4
  AST_STALL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !tick_i) |=> (busy_o && $stable(acc_q))); // R9
  AST_CHAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> chan_valid(chan_q, NCH)); // R3
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int unsigned NCH         = 3,
  parameter int unsigned RES_W       = 10,
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned PCLK_KHZ    = 100000,
  parameter int unsigned ADC_MAX_KHZ = 4500
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [11:0]          bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  input  logic [NCH*RES_W-1:0] ain,
  output logic                 irq
);
  localparam int unsigned DIV_RST = calc_divisor(PCLK_KHZ, ADC_MAX_KHZ);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RST);

  logic [31:0]      sel_q;
  logic             pwr_q, err_q, clk_en_q, irq_q;
  logic [DIV_W-1:0] div_q;
  logic [RES_W-1:0] result_q;

  // named internal events
  logic wr_sel, wr_ctrl, wr_clk, rd_res;
  logic start_req, conv_start, conv_busy, conv_done, conv_tick;
  logic [CH_W-1:0]  chan_code, chan_eff;
  logic [RES_W-1:0] conv_result;

  assign wr_sel    = bus_wr && (bus_addr == OFS_SEL);
  assign wr_ctrl   = bus_wr && (bus_addr == OFS_CTRL);
  assign wr_clk    = bus_wr && (bus_addr == OFS_CLK);
  assign rd_res    = bus_rd && (bus_addr == OFS_RES);
  assign start_req = wr_ctrl && bus_wdata[1] && bus_wdata[2];
  assign conv_start = start_req && !conv_busy;

  assign chan_code = sel_q[5:4];
  assign chan_eff  = chan_valid(chan_code, NCH) ? chan_code : '0;

  adc_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .en_i(clk_en_q), .clr_i(conv_start),
    .div_i(div_q), .tick_o(conv_tick)
  );

  adc_sar_core #(.NCH(NCH), .RES_W(RES_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start), .chan_i(chan_eff),
    .tick_i(conv_tick), .samples_i(ain), .busy_o(conv_busy),
    .done_o(conv_done), .result_o(conv_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '0;
      pwr_q    <= 1'b0;
      err_q    <= 1'b0;
      clk_en_q <= 1'b1;
      div_q    <= DIV_INIT;
      result_q <= '0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_sel) begin
        sel_q <= bus_wdata & SEL_KEEP_MASK;
        err_q <= !chan_valid(bus_wdata[5:4], NCH);
      end
      if (wr_ctrl) pwr_q <= bus_wdata[2];
      if (wr_clk) begin
        div_q    <= bus_wdata[DIV_W-1:0];
        clk_en_q <= bus_wdata[CLK_EN_BIT];
      end
      if (conv_done) result_q <= conv_result;
      if (conv_done)   irq_q <= 1'b1;   // completion wins over a clearing read
      else if (rd_res) irq_q <= 1'b0;
    end
  end

  assign irq = irq_q;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_SEL:  bus_rdata = sel_q;
      OFS_CTRL: bus_rdata = {27'b0, err_q, conv_busy, pwr_q, 2'b00};
      OFS_CLK:  bus_rdata = 32'(div_q) | (32'(clk_en_q) << CLK_EN_BIT);
      OFS_RES:  bus_rdata = 32'(result_q);
      default:  bus_rdata = '0;
    endcase
  end

  AST_START_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conv_busy) |-> $past(start_req)); // R5
  AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> irq); // R8
  AST_IRQ_READ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_res && !conv_done) |=> !irq); // R8
  AST_STROBE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_CTRL) |-> !bus_rdata[1]); // R6
  AST_ERR_ON_CODE3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel && bus_wdata[5:4] == 2'd3) |=> bus_rdata[4] || bus_addr != OFS_CTRL); // R3
  AST_RESULT_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_res |-> (bus_rdata[31:RES_W] == '0)); // R7
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam logic [11:0] A_SEL = 12'h004, A_CTRL = 12'h008,
                          A_CLK = 12'h010, A_RES = 12'h048;
  localparam int DIV_DEF = 100000 / 4500 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [29:0] ain = '0;
  logic        irq;
  int checks = 0, errors = 0;
  bit  finished = 0;

  always #5 clk = ~clk;

  adc_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ain(ain), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all bus tasks start and end just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [11:0] a, output logic [31:0] d);
    bus_rd = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic read_res(output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = A_RES;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_in(input int ch, input logic [9:0] v);
    ain[ch*10 +: 10] = v;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    peek(A_SEL, d);  chk("R1 select", d, 32'h0);
    peek(A_CTRL, d); chk("R1 control", d, 32'h0);
    peek(A_RES, d);  chk("R1 result", d, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    peek(A_CLK, d);  chk("R9 reset divisor", d, 32'h100 | DIV_DEF);
  endtask

  task automatic t_select;
    logic [31:0] d;
    wr(A_SEL, 32'hFFFF_FFFF);
    peek(A_SEL, d);  chk("R2 kept bits", d, 32'h0000_02B4);
    peek(A_CTRL, d); chk("R3 error set", d, 32'h10);
    wr(A_SEL, 32'h294);
    peek(A_SEL, d);  chk("R2 input 1 readback", d, 32'h294);
    peek(A_CTRL, d); chk("R3 error cleared", d, 32'h0);
  endtask

  task automatic t_conv_default;
    logic [31:0] d;
    wr(A_CTRL, 32'h6);
    peek(A_CTRL, d); chk("R4 R6 busy, strobe reads 0", d, 32'hC);
    idle(11*DIV_DEF - 1);
    peek(A_CTRL, d); chk("R4 busy before last tick", d, 32'hC);
    chk("R8 irq low while busy", {31'b0, irq}, 32'h0);
    idle(1);
    peek(A_CTRL, d); chk("R4 busy drops on tick 11", d, 32'h4);
    chk("R8 irq on completion", {31'b0, irq}, 32'h1);
    read_res(d);     chk("R7 result input 1", d, 32'h2AA);
    chk("R8 irq cleared by read", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_power_off;
    logic [31:0] d;
    wr(A_CLK, 32'h103);
    peek(A_CLK, d);  chk("R9 divisor write", d, 32'h103);
    wr(A_CTRL, 32'h2);
    peek(A_CTRL, d); chk("R5 no start without power", d, 32'h0);
    idle(40);
    chk("R5 no irq without power", {31'b0, irq}, 32'h0);
    peek(A_RES, d);  chk("R5 result unchanged", d, 32'h2AA);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] d;
    wr(A_SEL, 32'h284);
    wr(A_CTRL, 32'h6);
    idle(4);
    wr(A_CTRL, 32'h6);            // fifth edge after start
    idle(33 - 1 - 5);
    peek(A_CTRL, d); chk("R5 restart ignored, still busy", d, 32'hC);
    idle(1);
    peek(A_CTRL, d); chk("R5 completion time unchanged", d, 32'h4);
    read_res(d);     chk("R7 result input 0", d, 32'h155);
  endtask

  task automatic t_latch;
    logic [31:0] d;
    wr(A_SEL, 32'h2A4);
    wr(A_CTRL, 32'h6);
    idle(4);                      // sampled on edge 3
    set_in(2, 10'h001);
    wr(A_SEL, 32'h284);
    idle(40);
    read_res(d);     chk("R7 sample held after changes", d, 32'h3FF);
  endtask

  task automatic t_code3;
    logic [31:0] d;
    wr(A_SEL, 32'h2B4);
    peek(A_CTRL, d); chk("R3 error flag with power", d, 32'h14);
    wr(A_CTRL, 32'h6);
    idle(40);
    read_res(d);     chk("R3 code 3 converts input 0", d, 32'h155);
    peek(A_CTRL, d); chk("R3 error flag sticky", d, 32'h14);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    set_in(0, 10'h0F0);
    wr(A_CLK, 32'h003);
    wr(A_CTRL, 32'h6);
    idle(60);
    peek(A_CTRL, d); chk("R9 stalled while disabled", d, 32'h1C);
    chk("R9 no irq while disabled", {31'b0, irq}, 32'h0);
    wr(A_CLK, 32'h103);
    idle(40);
    chk("R9 irq after enable", {31'b0, irq}, 32'h1);
    read_res(d);     chk("R9 result after enable", d, 32'h0F0);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    set_in(1, 10'h123);
    wr(A_SEL, 32'h294);
    wr(A_CTRL, 32'h6);
    idle(32);
    read_res(d);     chk("R8 read on done edge returns old", d, 32'h0F0);
    chk("R8 set wins over clear", {31'b0, irq}, 32'h1);
    read_res(d);     chk("R8 new result", d, 32'h123);
    chk("R8 irq cleared after", {31'b0, irq}, 32'h0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    set_in(0, 10'h155); set_in(1, 10'h2AA); set_in(2, 10'h3FF);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_select();
    t_conv_default();
    t_power_off();
    t_busy_ignore();
    t_latch();
    t_code3();
    t_enable();
    t_collide();
    summary();
  end
endmodule